// File: doc/BRIEF.md
# Packed SIMD Add/Subtract Unit

This block performs lane-wise addition and subtraction on a 32-bit word. The word is split either into two 16-bit lanes or into four 8-bit lanes, and each lane is computed on its own. A lane never passes a carry or a borrow to the lane next to it. Each operation can run in three arithmetic modes: wrapping, halving (the average) and saturating. Each mode has a signed and an unsigned variant.

For 16-bit lanes, two cross operations are also available. They pair each half of the first operand with the opposite half of the second operand. In one of them the upper lane adds and the lower lane subtracts; in the other the roles are reversed.

The result path is purely combinational. The only state in the block is a sticky saturation flag. It records that some lane was clamped, and it stays set until the surrounding logic clears it explicitly.

Top module: `simd_addsub`

## Requirements
- R1: With `laneSel`=0, `mode`=00 and `opSel` set to 00 (add) or 01 (subtract), each 16-bit lane of `result` equals the matching lanes of `opA` and `opB` added or subtracted modulo 2^16. No carry or borrow crosses a lane boundary.
- R2: With `laneSel`=1 and `opSel` set to 00 or 01, the word is treated as four 8-bit lanes. Each lane is computed modulo 2^8 in wrapping mode, with no carry or borrow between lanes.
- R3: With `mode`=10 (halving), each lane first forms the sum or difference one bit wider than the lane. The operands are sign-extended when `isSigned`=1 and zero-extended when `isSigned`=0. The lane result is that value shifted right by one, which rounds toward minus infinity.
- R4: With `mode`=01 and `isSigned`=1, a lane whose signed result overflows is clamped. It goes to 0x7FFF or 0x7F when the true result is too high, and to 0x8000 or 0x80 when it is too low.
- R5: With `mode`=01 and `isSigned`=0, an unsigned add that overflows gives all ones in that lane, and an unsigned subtract that underflows gives zero.
- R6: `opSel`=10 (cross add/subtract) always uses 16-bit lanes, whatever `laneSel` says. The upper lane is opA[31:16] + opB[15:0] and the lower lane is opA[15:0] − opB[31:16], and all three modes apply.
- R7: `opSel`=11 (cross subtract/add) always uses 16-bit lanes. The upper lane is opA[31:16] − opB[15:0] and the lower lane is opA[15:0] + opB[31:16], and all three modes apply.
- R8: When any lane is clamped in a cycle, `satFlag` is high after the next rising clock edge. It then stays high while `clrSat` is low.
- R9: When `clrSat` is high, `satFlag` is low after the next edge, unless a lane clamps in that same cycle. In that case the flag stays set.
- R10: While `rst_n` is low, `satFlag` is 0.
- R11: `mode`=11 behaves exactly like `mode`=00, and no clamp is ever reported outside `mode`=01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the sticky flag |
| rst_n | input | 1 | Asynchronous active-low reset |
| opA | input | 32 | First packed operand |
| opB | input | 32 | Second packed operand |
| laneSel | input | 1 | 0: 16-bit lanes, 1: 8-bit lanes |
| opSel | input | 2 | 00 add, 01 sub, 10 cross add/sub, 11 cross sub/add |
| isSigned | input | 1 | 1: signed lanes, 0: unsigned |
| mode | input | 2 | 00 wrap, 01 saturate, 10 halving, 11 wrap |
| clrSat | input | 1 | Clears the sticky flag |
| result | output | 32 | Packed result |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
The assertions assume that the operand and control inputs are stable across each rising clock edge. The combinational clamp indication is only meaningful if it is sampled while the inputs are held. The assertions also assume that the wrap-mode lane sum is only compared when `laneSel`, `opSel` and `mode` together select a plain add.

The bench changes every input only on the falling edge and holds it for a full cycle. It exercises each control combination both with directed lane boundary values and with random words.

// File: rtl/simd_pkg.sv
package simd_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_XAS  = 2'b10,
    OP_XSA  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    MD_WRAP  = 2'b00,
    MD_SAT   = 2'b01,
    MD_HALF  = 2'b10,
    MD_WRAP2 = 2'b11
  } mode_e;

  // strobes handed from control to datapath
  typedef struct packed {
    logic narrow;  // 8-bit lanes active
    logic swapB;   // pair each wide lane with its neighbour's B half
    logic subHi;   // odd wide lanes subtract
    logic subLo;   // even wide lanes (and all narrow lanes) subtract
    logic sgn;
    logic sat;
    logic half;
  } strobe_t;
endpackage

// File: rtl/simd_ctrl.sv
module simd_ctrl
  import simd_pkg::*;
(
  input  logic       laneSel,
  input  logic [1:0] opSel,
  input  logic       isSigned,
  input  logic [1:0] mode,
  output strobe_t    strb
);
  always_comb begin
    strb        = '0;
    strb.swapB  = opSel[1];
    strb.narrow = laneSel & ~opSel[1];
    strb.sgn    = isSigned;
    strb.sat    = (mode == MD_SAT);
    strb.half   = (mode == MD_HALF);
    unique case (op_e'(opSel))
      OP_ADD: begin strb.subHi = 1'b0; strb.subLo = 1'b0; end
      OP_SUB: begin strb.subHi = 1'b1; strb.subLo = 1'b1; end
      OP_XAS: begin strb.subHi = 1'b0; strb.subLo = 1'b1; end
      default: begin strb.subHi = 1'b1; strb.subLo = 1'b0; end
    endcase
  end
endmodule

// File: rtl/simd_lane.sv
module simd_lane #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         sgn,
  input  logic         sat,
  input  logic         half,
  output logic [W-1:0] res,
  output logic         clamped
);
  logic [W:0] extA, extB, raw;
  logic       over;

  always_comb begin
    extA = {sgn & a[W-1], a};
    extB = {sgn & b[W-1], b};
    raw  = sub ? (extA - extB) : (extA + extB);
    // signed: top two bits disagree; unsigned: carry/borrow out
    over = sgn ? (raw[W] ^ raw[W-1]) : raw[W];
    clamped = 1'b0;
    if (half) begin
      res = raw[W:1];
    end else if (sat && over) begin
      clamped = 1'b1;
      if (sgn) res = raw[W] ? {1'b1, {(W-1){1'b0}}} : {1'b0, {(W-1){1'b1}}};
      else     res = sub ? '0 : '1;
    end else begin
      res = raw[W-1:0];
    end
  end
endmodule

// File: rtl/simd_dp.sv
module simd_dp
  import simd_pkg::*;
#(
  parameter int DATA_W   = 32,   // multiple of 2*WIDE_W
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  strobe_t           strb,
  output logic [DATA_W-1:0] result,
  output logic              anySat
);
  localparam int NWIDE   = DATA_W / WIDE_W;
  localparam int NNARROW = DATA_W / NARROW_W;

  logic [DATA_W-1:0]  resWide, resNarrow;
  logic [NWIDE-1:0]   satWide;
  logic [NNARROW-1:0] satNarrow;

  for (genvar i = 0; i < NWIDE; i++) begin : g_wide
    localparam int PARTNER = i ^ 1;
    logic [WIDE_W-1:0] bSel;
    assign bSel = strb.swapB ? opB[PARTNER*WIDE_W +: WIDE_W] : opB[i*WIDE_W +: WIDE_W];
    simd_lane #(.W(WIDE_W)) u_lane (
      .a      (opA[i*WIDE_W +: WIDE_W]),
      .b      (bSel),
      .sub    ((i % 2 == 1) ? strb.subHi : strb.subLo),
      .sgn    (strb.sgn),
      .sat    (strb.sat),
      .half   (strb.half),
      .res    (resWide[i*WIDE_W +: WIDE_W]),
      .clamped(satWide[i])
    );
  end

  for (genvar j = 0; j < NNARROW; j++) begin : g_narrow
    simd_lane #(.W(NARROW_W)) u_lane (
      .a      (opA[j*NARROW_W +: NARROW_W]),
      .b      (opB[j*NARROW_W +: NARROW_W]),
      .sub    (strb.subLo),
      .sgn    (strb.sgn),
      .sat    (strb.sat),
      .half   (strb.half),
      .res    (resNarrow[j*NARROW_W +: NARROW_W]),
      .clamped(satNarrow[j])
    );
  end

  assign result = strb.narrow ? resNarrow : resWide;
  assign anySat = strb.narrow ? (|satNarrow) : (|satWide);
endmodule

// File: rtl/simd_addsub.sv
module simd_addsub
  import simd_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int WIDE_W   = 16,
  parameter int NARROW_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              laneSel,
  input  logic [1:0]        opSel,
  input  logic              isSigned,
  input  logic [1:0]        mode,
  input  logic              clrSat,
  output logic [DATA_W-1:0] result,
  output logic              satFlag
);
  strobe_t strb;
  logic    anySat;

  simd_ctrl u_ctrl (
    .laneSel (laneSel),
    .opSel   (opSel),
    .isSigned(isSigned),
    .mode    (mode),
    .strb    (strb)
  );

  simd_dp #(.DATA_W(DATA_W), .WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_dp (
    .opA   (opA),
    .opB   (opB),
    .strb  (strb),
    .result(result),
    .anySat(anySat)
  );

  // a clamp in the clearing cycle wins over the clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) satFlag <= 1'b0;
    else        satFlag <= (satFlag & ~clrSat) | anySat;
  end
endmodule

// File: rtl/simd_addsub_chk.sv
module simd_addsub_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic              laneSel,
  input logic [1:0]        opSel,
  input logic [1:0]        mode,
  input logic              clrSat,
  input logic [DATA_W-1:0] result,
  input logic              satFlag,
  input logic              anySat
);
  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    anySat |=> satFlag);

  // R8
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (satFlag && !clrSat) |=> satFlag);

  // R9
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clrSat && !anySat) |=> !satFlag);

  // R11
  no_clamp_outside_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'b01) |-> !anySat);

  // R1
  wrap_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00 && opSel == 2'b00 && !laneSel) |->
      result[15:0] == 16'(opA[15:0] + opB[15:0]));

  // R10
  always @(posedge clk)
    if (!rst_n) reset_flag_chk: assert (!satFlag);
endmodule

bind simd_addsub simd_addsub_chk #(.DATA_W(DATA_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .opA    (opA),
  .opB    (opB),
  .laneSel(laneSel),
  .opSel  (opSel),
  .mode   (mode),
  .clrSat (clrSat),
  .result (result),
  .satFlag(satFlag),
  .anySat (anySat)
);

// File: tb/tb_simd_addsub.sv
`timescale 1ns/1ps
module tb_simd_addsub;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] opA = '0, opB = '0;
  logic        laneSel = 1'b0, isSigned = 1'b0, clrSat = 1'b0;
  logic [1:0]  opSel = '0, mode = '0;
  logic [31:0] result;
  logic        satFlag;

  int total = 0, bad = 0;
  bit expFlag = 1'b0;
  bit driverDone = 1'b0;

  typedef struct {
    logic [31:0] expRes;
    bit          expFlag;
    string       tag;
  } item_t;
  item_t sb[$];

  always #4 clk = ~clk;   // 125 MHz

  simd_addsub dut (
    .clk(clk), .rst_n(rst_n), .opA(opA), .opB(opB), .laneSel(laneSel),
    .opSel(opSel), .isSigned(isSigned), .mode(mode), .clrSat(clrSat),
    .result(result), .satFlag(satFlag)
  );

  // independent reference from the requirements
  function automatic void refModel(input logic [31:0] a, input logic [31:0] b,
      input bit ls, input logic [1:0] op, input bit sg, input logic [1:0] md,
      output logic [31:0] r, output bit s);
    int w = (ls && !op[1]) ? 8 : 16;
    longint mask = (64'sd1 <<< w) - 1;
    r = '0; s = 1'b0;
    for (int k = 0; k < 32 / w; k++) begin
      int bk = op[1] ? (k ^ 1) : k;
      longint ai = (longint'(a) >> (k * w)) & mask;
      longint bi = (longint'(b) >> (bk * w)) & mask;
      bit doSub = (op == 2'b01) || (op == 2'b10 && k % 2 == 0) || (op == 2'b11 && k % 2 == 1);
      longint v, lo, hi;
      if (sg) begin
        if (ai >= (64'sd1 <<< (w - 1))) ai -= (64'sd1 <<< w);
        if (bi >= (64'sd1 <<< (w - 1))) bi -= (64'sd1 <<< w);
      end
      v = doSub ? ai - bi : ai + bi;
      if (md == 2'b10) v = v >>> 1;
      else if (md == 2'b01) begin
        lo = sg ? -(64'sd1 <<< (w - 1)) : 0;
        hi = sg ? (64'sd1 <<< (w - 1)) - 1 : mask;
        if (v > hi) begin v = hi; s = 1'b1; end
        if (v < lo) begin v = lo; s = 1'b1; end
      end
      r = r | (32'(v & mask) << (k * w));
    end
  endfunction

  task automatic drive(input logic [31:0] a, input logic [31:0] b, input bit ls,
      input logic [1:0] op, input bit sg, input logic [1:0] md, input bit clr,
      input string tag);
    item_t it;
    logic [31:0] r;
    bit s;
    @(negedge clk);
    opA = a; opB = b; laneSel = ls; opSel = op; isSigned = sg; mode = md; clrSat = clr;
    refModel(a, b, ls, op, sg, md, r, s);
    expFlag = (expFlag & ~clr) | s;
    it.expRes = r; it.expFlag = expFlag; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic finishRun();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor: pops one item per cycle, after the edge that commits the flag
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        total++;
        if (result !== it.expRes) begin
          bad++;
          $display("FAIL %s result act=%h exp=%h", it.tag, result, it.expRes);
        end
        total++;
        if (satFlag !== it.expFlag) begin
          bad++;
          $display("FAIL %s/R8 satFlag act=%0b exp=%0b", it.tag, satFlag, it.expFlag);
        end
      end else if (driverDone) begin
        finishRun();
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    total++;
    if (satFlag !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset satFlag act=%0b exp=0", satFlag);
    end
    @(negedge clk) rst_n = 1'b1;

    // R1 wrap 16-bit, no carry between lanes
    drive(32'h7FFF_FFFF, 32'h0001_0001, 0, 2'b00, 0, 2'b00, 0, "R1");
    drive(32'h0000_0000, 32'h0000_0001, 0, 2'b01, 1, 2'b00, 0, "R1");
    // R2 wrap 8-bit
    drive(32'hFF01_80FF, 32'h0101_8001, 1, 2'b00, 0, 2'b00, 0, "R2");
    drive(32'h0010_0000, 32'h0101_0101, 1, 2'b01, 1, 2'b00, 0, "R2");
    // R3 halving
    drive(32'h7FFF_FFFF, 32'h7FFF_FFFF, 0, 2'b00, 1, 2'b10, 0, "R3");
    drive(32'hFFFF_0000, 32'hFFFF_0001, 0, 2'b01, 0, 2'b10, 0, "R3");
    drive(32'h80FF_0003, 32'h80FF_FF00, 1, 2'b00, 1, 2'b10, 0, "R3");
    drive(32'h0000_0001, 32'h0101_0102, 1, 2'b01, 0, 2'b10, 0, "R3");
    // R4 signed saturate
    drive(32'h7FFF_8000, 32'h0001_0001, 0, 2'b00, 1, 2'b01, 0, "R4");
    drive(32'h7F80_0000, 32'h0101_0000, 1, 2'b00, 1, 2'b01, 1, "R4");
    drive(32'h8000_7FFF, 32'h0001_FFFF, 0, 2'b01, 1, 2'b01, 1, "R4");
    // R9 clear with no clamp
    drive(32'h0001_0001, 32'h0001_0001, 0, 2'b00, 1, 2'b01, 1, "R9");
    // R5 unsigned saturate
    drive(32'hFFFF_0001, 32'h0001_0002, 0, 2'b00, 0, 2'b01, 0, "R5");
    drive(32'h0001_0005, 32'h0002_0003, 0, 2'b01, 0, 2'b01, 1, "R5");
    drive(32'hF0FF_0110, 32'h2001_0220, 1, 2'b00, 0, 2'b01, 1, "R5");
    drive(32'h10FF_0110, 32'h2001_0220, 1, 2'b01, 0, 2'b01, 1, "R5");
    // R6 cross add/sub, laneSel ignored
    drive(32'h1000_2000, 32'h0003_0005, 0, 2'b10, 0, 2'b00, 1, "R6");
    drive(32'h1000_2000, 32'h0003_0005, 1, 2'b10, 0, 2'b00, 0, "R6");
    drive(32'h7FFF_8000, 32'h0001_0001, 0, 2'b10, 1, 2'b01, 0, "R6");
    drive(32'hFFFF_0001, 32'h0003_0002, 1, 2'b10, 0, 2'b10, 1, "R6");
    // R7 cross sub/add
    drive(32'h1000_2000, 32'h0003_0005, 1, 2'b11, 0, 2'b00, 0, "R7");
    drive(32'h8000_7FFF, 32'h0001_0001, 0, 2'b11, 1, 2'b01, 1, "R7");
    drive(32'h0000_FFFF, 32'h0001_0001, 0, 2'b11, 0, 2'b01, 0, "R7");
    drive(32'h0003_8001, 32'h7FFF_0001, 0, 2'b11, 1, 2'b10, 1, "R7");
    // R8 flag holds without clamp, then R9 set wins over clear
    drive(32'h7FFF_0000, 32'h0001_0000, 0, 2'b00, 1, 2'b01, 0, "R8");
    drive(32'h0000_0000, 32'h0000_0000, 0, 2'b00, 1, 2'b00, 0, "R8");
    drive(32'h7FFF_0000, 32'h0001_0000, 0, 2'b00, 1, 2'b01, 1, "R9");
    drive(32'h0000_0000, 32'h0000_0000, 0, 2'b00, 1, 2'b00, 1, "R9");
    // R11 mode 11 is wrap, no clamp
    drive(32'h7FFF_FFFF, 32'h0001_0001, 0, 2'b00, 1, 2'b11, 0, "R11");
    drive(32'h7F00_FF80, 32'h0100_0180, 1, 2'b00, 0, 2'b11, 0, "R11");

    for (int n = 0; n < 400; n++)
      drive($urandom, $urandom, 1'($urandom), 2'($urandom), 1'($urandom),
            2'($urandom), ($urandom % 8 == 0), "RND/R1");

    driverDone = 1'b1;
  end
endmodule